// File: doc/BRIEF.md
# Byte and Halfword Lane Permute Unit

The unit takes two 32-bit operand words, X and Y, and returns two 32-bit result words, P and Q. Each result is built by moving whole lanes of the operands. Five permutations are available. Byte transpose and halfword transpose exchange lanes between the two words as if they formed a two-row matrix. Byte interleave and halfword interleave merge the lanes of the two words alternately. Byte de-interleave separates even-numbered lanes from odd-numbered ones. The three op codes that name no permutation pass the operands through unchanged. Lane 0 is always the least significant lane.

Every output lane is chosen by one multiplexer stage. A small router decides, for each op, which operand lane feeds each output lane. Both results are formed in the same cycle and registered together, so a permute issued in one cycle is visible on P and Q after the next rising clock edge. The byte interleave and byte de-interleave are exact inverses of each other. Feeding a byte transpose's results back into it with the words swapped gives the original pair back in swapped order. This lets a caller undo either operation without a separate inverse op.

Top module: `lane_perm_unit`

## Requirements
- R1: While rst_n is low, p_o and q_o read zero; the clear takes effect without waiting for a clock edge.
- R2: Op code 1 (byte transpose) gives p_o = {X2, Y2, X0, Y0} and q_o = {X3, Y3, X1, Y1}, listed most significant byte first, where Xn is bits 8n+7..8n of x_i.
- R3: Op code 2 (halfword transpose) gives p_o = {x_i[15:0], y_i[15:0]} and q_o = {x_i[31:16], y_i[31:16]}.
- R4: Op code 3 (byte de-interleave) gives p_o = {Y2, Y0, X2, X0} and q_o = {Y3, Y1, X3, X1}.
- R5: Op code 4 (byte interleave) gives p_o = {Y1, X1, Y0, X0} and q_o = {Y3, X3, Y2, X2}.
- R6: Op code 5 (halfword interleave) gives p_o = {y_i[15:0], x_i[15:0]} and q_o = {y_i[31:16], x_i[31:16]}.
- R7: Op codes 0, 6 and 7 give p_o = x_i and q_o = y_i.
- R8: Results for inputs present at a rising clock edge appear on p_o and q_o right after that edge, and hold until the next edge.
- R9: Applying op 3 to the p_o and q_o of an op 4 (p_o as x_i, q_o as y_i) returns the original x_i and y_i.
- R10: Applying op 1 to the results of an op 1 with the words swapped (q_o as x_i, p_o as y_i) returns p_o = original y_i and q_o = original x_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Permutation select |
| x_i | input | 32 | First operand word |
| y_i | input | 32 | Second operand word |
| p_o | output | 32 | First result word |
| q_o | output | 32 | Second result word |

## Verification
Each result is due one clock after its operands: the value on x_i, y_i and op_i at a rising edge is on p_o and q_o from just after that edge. The bench therefore changes inputs on the falling edge and reads both outputs at the following falling edge, one full rising edge later. The round-trip checks chain two such transactions, so the second permute uses outputs read a whole cycle after the first one was issued. The reset check reads the outputs a moment after rst_n falls, with no clock edge in between.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

  // Lanes per word; the permutation patterns are defined on four lanes.
  localparam int LANES   = 4;
  localparam int OUT_LN  = 2 * LANES;
  localparam int IDX_W   = $clog2(LANES);

  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_TRN8  = 3'd1,
    OP_TRN16 = 3'd2,
    OP_UZP8  = 3'd3,
    OP_ZIP8  = 3'd4,
    OP_ZIP16 = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } perm_op_e;

  // Source of one output lane: which operand word, which lane in it.
  typedef struct packed {
    logic             from_y;
    logic [IDX_W-1:0] idx;
  } lane_src_t;

  // Output lane numbering: 0..3 are lanes of P, 4..7 are lanes of Q.
  function automatic lane_src_t route(input perm_op_e op, input logic [2:0] lane);
    lane_src_t  r;
    logic [1:0] k;
    logic       w;
    int         n;
    k = lane[1:0];
    w = lane[2];
    case (op)
      OP_TRN8: begin
        r.from_y = ~k[0];
        n        = 2 * int'(k[1]) + int'(w);
      end
      OP_UZP8: begin
        r.from_y = k[1];
        n        = 2 * int'(k[0]) + int'(w);
      end
      OP_ZIP8: begin
        r.from_y = k[0];
        n        = int'(k[1]) + 2 * int'(w);
      end
      OP_TRN16: begin
        r.from_y = ~k[1];
        n        = int'(k[0]) + 2 * int'(w);
      end
      OP_ZIP16: begin
        r.from_y = k[1];
        n        = int'(k[0]) + 2 * int'(w);
      end
      default: begin
        r.from_y = w;
        n        = int'(k);
      end
    endcase
    r.idx = IDX_W'(n);
    return r;
  endfunction

endpackage

// File: rtl/lane_perm_route.sv
module lane_perm_route
  import lane_perm_pkg::*;
(
  input  logic [2:0]             op_i,
  output lane_src_t [OUT_LN-1:0] src_o
);

  perm_op_e op;
  assign op = perm_op_e'(op_i);

  for (genvar g = 0; g < OUT_LN; g++) begin : g_lane
    assign src_o[g] = route(op, 3'(g));
  end

endmodule

// File: rtl/lane_perm_xbar.sv
module lane_perm_xbar
  import lane_perm_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0]      x_i,
  input  logic [WORD_W-1:0]      y_i,
  input  lane_src_t [OUT_LN-1:0] src_i,
  output logic [WORD_W-1:0]      p_o,
  output logic [WORD_W-1:0]      q_o
);

  logic [LANE_W-1:0] xl [LANES];
  logic [LANE_W-1:0] yl [LANES];
  logic [OUT_LN-1:0][LANE_W-1:0] ol;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign xl[i] = x_i[i*LANE_W +: LANE_W];
    assign yl[i] = y_i[i*LANE_W +: LANE_W];
  end

  for (genvar g = 0; g < OUT_LN; g++) begin : g_mux
    always_comb begin
      if (src_i[g].from_y) ol[g] = yl[src_i[g].idx];
      else                 ol[g] = xl[src_i[g].idx];
    end
  end

  assign p_o = ol[LANES-1:0];
  assign q_o = ol[OUT_LN-1:LANES];

endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
  import lane_perm_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  output logic [WORD_W-1:0] p_o,
  output logic [WORD_W-1:0] q_o
);

  lane_src_t [OUT_LN-1:0] src;
  logic [WORD_W-1:0] p_d, q_d;
  logic [WORD_W-1:0] p_q, q_q;

  lane_perm_route u_route (
    .op_i  (op_i),
    .src_o (src)
  );

  lane_perm_xbar #(.LANE_W(LANE_W)) u_xbar (
    .x_i   (x_i),
    .y_i   (y_i),
    .src_i (src),
    .p_o   (p_d),
    .q_o   (q_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      q_q <= '0;
    end else begin
      p_q <= p_d;
      q_q <= q_d;
    end
  end

  assign p_o = p_q;
  assign q_o = q_q;

endmodule

// File: rtl/lane_perm_chk.sv
module lane_perm_chk
  import lane_perm_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic [WORD_W-1:0] x_i,
  input logic [WORD_W-1:0] y_i,
  input logic [WORD_W-1:0] p_o,
  input logic [WORD_W-1:0] q_o
);

  localparam int H = 2 * LANE_W;

  // Set once a full clock edge has been taken out of reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic logic [LANE_W-1:0] ln(input logic [WORD_W-1:0] w, input int i);
    return w[i*LANE_W +: LANE_W];
  endfunction

  // R2 and R8
  a_r2_byte_transpose: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 3'd1) |->
      (p_o == {ln($past(x_i),2), ln($past(y_i),2), ln($past(x_i),0), ln($past(y_i),0)}) &&
      (q_o == {ln($past(x_i),3), ln($past(y_i),3), ln($past(x_i),1), ln($past(y_i),1)}));

  // R3
  a_r3_half_transpose: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 3'd2) |->
      (p_o == {$past(x_i[H-1:0]), $past(y_i[H-1:0])}) &&
      (q_o == {$past(x_i[WORD_W-1:H]), $past(y_i[WORD_W-1:H])}));

  // R4
  a_r4_byte_unzip: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 3'd3) |->
      (p_o == {ln($past(y_i),2), ln($past(y_i),0), ln($past(x_i),2), ln($past(x_i),0)}) &&
      (q_o == {ln($past(y_i),3), ln($past(y_i),1), ln($past(x_i),3), ln($past(x_i),1)}));

  // R5
  a_r5_byte_zip: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 3'd4) |->
      (p_o == {ln($past(y_i),1), ln($past(x_i),1), ln($past(y_i),0), ln($past(x_i),0)}) &&
      (q_o == {ln($past(y_i),3), ln($past(x_i),3), ln($past(y_i),2), ln($past(x_i),2)}));

  // R6
  a_r6_half_zip: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 3'd5) |->
      (p_o == {$past(y_i[H-1:0]), $past(x_i[H-1:0])}) &&
      (q_o == {$past(y_i[WORD_W-1:H]), $past(x_i[WORD_W-1:H])}));

  // R7
  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ($past(op_i) == 3'd0 || $past(op_i) == 3'd6 || $past(op_i) == 3'd7)) |->
      (p_o == $past(x_i)) && (q_o == $past(y_i)));

  // R8: outputs move only on a clock edge, so a stable input set gives stable outputs
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(op_i) && $stable(x_i) && $stable(y_i) && $past(armed)) |=>
      ($stable(p_o) && $stable(q_o)));

endmodule

bind lane_perm_unit lane_perm_chk #(.LANE_W(LANE_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_i  (op_i),
  .x_i   (x_i),
  .y_i   (y_i),
  .p_o   (p_o),
  .q_o   (q_o)
);

// File: tb/tb_lane_perm_unit.sv
module tb_lane_perm_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [31:0] x_i, y_i;
  logic [31:0] p_o, q_o;

  int n_vec;
  int n_bad;
  int cyc;
  logic [31:0] rng;

  lane_perm_unit dut (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .x_i   (x_i),
    .y_i   (y_i),
    .p_o   (p_o),
    .q_o   (q_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
        summary();
      end
    end
  end

  function automatic logic [7:0] bt(input logic [31:0] w, input int i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [63:0] expect_pq(input logic [2:0] op, input logic [31:0] x,
                                            input logic [31:0] y);
    logic [31:0] p, q;
    case (op)
      3'd1: begin
        p = {bt(x,2), bt(y,2), bt(x,0), bt(y,0)};
        q = {bt(x,3), bt(y,3), bt(x,1), bt(y,1)};
      end
      3'd2: begin
        p = {x[15:0], y[15:0]};
        q = {x[31:16], y[31:16]};
      end
      3'd3: begin
        p = {bt(y,2), bt(y,0), bt(x,2), bt(x,0)};
        q = {bt(y,3), bt(y,1), bt(x,3), bt(x,1)};
      end
      3'd4: begin
        p = {bt(y,1), bt(x,1), bt(y,0), bt(x,0)};
        q = {bt(y,3), bt(x,3), bt(y,2), bt(x,2)};
      end
      3'd5: begin
        p = {y[15:0], x[15:0]};
        q = {y[31:16], x[31:16]};
      end
      default: begin
        p = x;
        q = y;
      end
    endcase
    return {p, q};
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input string req, input logic [31:0] ep, input logic [31:0] eq);
    n_vec++;
    if (p_o !== ep || q_o !== eq) begin
      n_bad++;
      $display("FAIL %s: p=%h q=%h expected p=%h q=%h", req, p_o, q_o, ep, eq);
    end
  endtask

  // Drive on a falling edge; the rising edge captures; read at the next falling edge (R8).
  task automatic issue(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op_i = op;
    x_i  = x;
    y_i  = y;
    @(negedge clk);
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    logic [63:0] e;
    issue(op, x, y);
    e = expect_pq(op, x, y);
    check(req_of(op), e[63:32], e[31:0]);
  endtask

  initial begin
    logic [31:0] ox, oy, p1, q1;
    n_vec = 0;
    n_bad = 0;
    rng   = 32'h1F2E_3D4C;
    rst_n = 1'b0;
    op_i  = 3'd1;
    x_i   = 32'hDEAD_BEEF;
    y_i   = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 32'h0);
    rst_n = 1'b1;

    // Distinct-lane pattern per op, then walking and random vectors
    for (int op = 0; op < 8; op++) begin
      apply(3'(op), 32'h0302_0100, 32'h1312_1110);
      apply(3'(op), 32'hA3A2_A1A0, 32'hB3B2_B1B0);
      for (int b = 0; b < 32; b++) begin
        apply(3'(op), 32'h1 << b, 32'h8000_0000 >> b);
      end
      for (int r = 0; r < 200; r++) begin
        apply(3'(op), next_rand(), next_rand());
      end
    end

    // R8: inputs held for several cycles keep the same result
    issue(3'd4, 32'h4433_2211, 32'h8877_6655);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R8 hold", 32'h6622_5511, 32'h8844_7733);
    end

    // R9: byte unzip undoes byte zip
    for (int r = 0; r < 300; r++) begin
      ox = next_rand();
      oy = next_rand();
      issue(3'd4, ox, oy);
      p1 = p_o;
      q1 = q_o;
      issue(3'd3, p1, q1);
      check("R9 zip/unzip round trip", ox, oy);
    end

    // R10: byte transpose twice with swapped words returns (y, x)
    for (int r = 0; r < 300; r++) begin
      ox = next_rand();
      oy = next_rand();
      issue(3'd1, ox, oy);
      p1 = p_o;
      q1 = q_o;
      issue(3'd1, q1, p1);
      check("R10 double transpose", oy, ox);
    end

    // R1: asynchronous clear in the middle of operation, no clock edge needed
    issue(3'd0, 32'h1234_5678, 32'h9ABC_DEF0);
    check("R7 before reset", 32'h1234_5678, 32'h9ABC_DEF0);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 32'h0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'd2, 32'hAAAA_BBBB, 32'hCCCC_DDDD);

    summary();
  end

endmodule